// File: doc/BRIEF.md
# Page Translation Unit with Four-Way Associative Lookaside Buffer

The unit turns a virtual address into a physical address. The low 12 bits of the address are the byte offset inside a 4 KB page and pass through unchanged. The bits above them form the virtual page number. A small, fully associative lookaside buffer is searched first. On a miss, a flat on-chip page table with one slot per virtual page is read. When that slot is marked as not resident, a fresh physical page is handed out by a counting allocator. Every miss loads its translation into the lookaside buffer. Each answer comes with a two-bit result code.

Replacement uses an age counter in each buffer entry. The four entries hold the ages 1 to 4, and a larger age means more recently used. Software, or a bench, preloads both structures through a write port while the unit is idle. It can inspect both structures through combinational peek ports.

Top module: `vmem_xlate`

## Requirements
- R1: The response address is the physical page number followed by the request's low 12 offset bits, unchanged; the virtual page number is request bits 15:12.
- R2: A request whose page number matches a valid buffer entry answers with code 00 and that entry's physical page, with resp_valid high after the first clock edge following acceptance. Code 11 is never produced.
- R3: A buffer miss whose page-table slot is valid answers with code 01 and the slot's physical page, with resp_valid high after the second clock edge following acceptance.
- R4: A buffer miss whose page-table slot is not resident answers with code 10, also after two edges. It receives the allocator's current page number, writes that number into the slot as valid, and advances the allocator by one. The allocator starts at 13.
- R5: When an entry is hit, its age becomes 4, every entry whose age exceeded that entry's old age drops by one, and the other entries keep their ages.
- R6: On every miss, the translation is written into an invalid entry if one exists (lowest index first). Otherwise it goes into the entry with the lowest age. The chosen entry becomes valid with the new tag and page, and the R5 age rule is applied to it.
- R7: ready is low only during the page-table step of a miss. A request presented while ready is low is ignored and yields no response.
- R8: After reset, ready is high and resp_valid is low. All buffer entries are invalid, every page-table slot is not resident, and the allocator holds 13.
- R9: An initialisation write stores the given valid bit, tag, page and age into the addressed buffer entry, or the given valid bit and page into the addressed page-table slot. The peek ports show the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 16 | Virtual address |
| ready | output | 1 | Unit can accept a request |
| resp_valid | output | 1 | Response valid for one cycle |
| resp_code | output | 2 | 00 hit, 01 table hit, 10 fault |
| resp_pa | output | 17 | Physical address |
| init_tlb_we | input | 1 | Buffer entry write strobe |
| init_tlb_idx | input | 2 | Buffer entry index |
| init_tlb_valid | input | 1 | Valid bit to write |
| init_tlb_tag | input | 4 | Tag to write |
| init_tlb_ppn | input | 5 | Physical page to write |
| init_tlb_age | input | 3 | Age to write |
| init_pt_we | input | 1 | Page-table write strobe |
| init_pt_idx | input | 4 | Page-table slot |
| init_pt_valid | input | 1 | Resident bit to write |
| init_pt_ppn | input | 5 | Physical page to write |
| peek_tlb_idx | input | 2 | Buffer entry to show |
| peek_tlb_valid | output | 1 | Shown entry valid |
| peek_tlb_tag | output | 4 | Shown entry tag |
| peek_tlb_ppn | output | 5 | Shown entry page |
| peek_tlb_age | output | 3 | Shown entry age |
| peek_pt_idx | input | 4 | Page-table slot to show |
| peek_pt_valid | output | 1 | Shown slot resident |
| peek_pt_ppn | output | 5 | Shown slot page |

## Verification
The assertions assume that initialisation writes happen only while the unit is idle. They also assume that a request is never raised in the same cycle as an initialisation write. The bench issues all preload writes before the first request and keeps both strobes low during the address stream. The allocator checks assume that fewer faults occur than there are free page numbers above 13. The stream has at most nine non-resident pages, so the allocator never wraps.

// File: rtl/xl_pkg.sv
package xl_pkg;

    localparam int OFFS_W     = 12;
    localparam int VPN_W      = 4;
    localparam int PPN_W      = 5;
    localparam int TLB_N      = 4;
    localparam int FIRST_FREE = 13;

    localparam int AGE_W  = $clog2(TLB_N + 1);
    localparam int TIDX_W = $clog2(TLB_N);
    localparam int PT_N   = 1 << VPN_W;
    localparam int VA_W   = VPN_W + OFFS_W;
    localparam int PA_W   = PPN_W + OFFS_W;

    typedef enum logic [1:0] {
        RC_HIT   = 2'b00,
        RC_TABLE = 2'b01,
        RC_FAULT = 2'b10
    } rcode_e;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
        logic [AGE_W-1:0] age;
    } tlbe_t;

    typedef struct packed {
        logic             valid;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    // Age of one entry after the entry holding age 'pivot' is promoted.
    function automatic logic [AGE_W-1:0] age_after(
        input logic [AGE_W-1:0] cur,
        input logic [AGE_W-1:0] pivot,
        input logic             is_target
    );
        if (is_target)
            return AGE_W'(TLB_N);
        else if (cur > pivot)
            return cur - AGE_W'(1);
        else
            return cur;
    endfunction

endpackage

// File: rtl/xl_tlb.sv
module xl_tlb
    import xl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    input  logic              touch_en,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              init_we,
    input  logic [TIDX_W-1:0] init_idx,
    input  tlbe_t             init_ent,
    input  logic [TIDX_W-1:0] peek_idx,
    output tlbe_t             peek_ent
);

    tlbe_t ent [TLB_N];

    logic [TLB_N-1:0]  match;
    logic [TIDX_W-1:0] hit_idx;
    logic [TIDX_W-1:0] vic_idx;
    logic [TIDX_W-1:0] upd_idx;
    logic [AGE_W-1:0]  pivot;
    logic              upd_en;

    genvar g;
    generate
        for (g = 0; g < TLB_N; g++) begin : g_cmp
            assign match[g] = ent[g].valid && (ent[g].tag == lk_vpn);
        end
    endgenerate

    always_comb begin
        hit_idx = '0;
        for (int i = TLB_N - 1; i >= 0; i--)
            if (match[i]) hit_idx = TIDX_W'(i);
    end

    assign lk_hit = |match;
    assign lk_ppn = ent[hit_idx].ppn;

    // Victim: lowest-index invalid entry, otherwise the oldest one.
    always_comb begin
        logic             found;
        logic [AGE_W-1:0] best;
        found   = 1'b0;
        best    = '1;
        vic_idx = '0;
        for (int i = 0; i < TLB_N; i++) begin
            if (!found && !ent[i].valid) begin
                found   = 1'b1;
                vic_idx = TIDX_W'(i);
            end
        end
        if (!found) begin
            for (int i = 0; i < TLB_N; i++) begin
                if (ent[i].age < best) begin
                    best    = ent[i].age;
                    vic_idx = TIDX_W'(i);
                end
            end
        end
    end

    assign upd_en  = touch_en || fill_en;
    assign upd_idx = fill_en ? vic_idx : hit_idx;
    assign pivot   = ent[upd_idx].age;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TLB_N; i++) begin
                ent[i].valid <= 1'b0;
                ent[i].tag   <= '0;
                ent[i].ppn   <= '0;
                ent[i].age   <= AGE_W'(i + 1);
            end
        end else if (init_we) begin
            ent[init_idx] <= init_ent;
        end else if (upd_en) begin
            for (int i = 0; i < TLB_N; i++) begin
                ent[i].age <= age_after(ent[i].age, pivot, upd_idx == TIDX_W'(i));
                if (fill_en && vic_idx == TIDX_W'(i)) begin
                    ent[i].valid <= 1'b1;
                    ent[i].tag   <= fill_vpn;
                    ent[i].ppn   <= fill_ppn;
                end
            end
        end
    end

    assign peek_ent = ent[peek_idx];

endmodule

// File: rtl/xl_ptab.sv
module xl_ptab
    import xl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] rd_vpn,
    output pte_t             rd_ent,
    input  logic             alloc_en,
    output logic [PPN_W-1:0] alloc_ppn,
    input  logic             init_we,
    input  logic [VPN_W-1:0] init_idx,
    input  pte_t             init_ent,
    input  logic [VPN_W-1:0] peek_idx,
    output pte_t             peek_ent
);

    pte_t             slot [PT_N];
    logic [PPN_W-1:0] next_free;

    assign rd_ent    = slot[rd_vpn];
    assign alloc_ppn = next_free;
    assign peek_ent  = slot[peek_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PT_N; i++)
                slot[i] <= '0;
            next_free <= PPN_W'(FIRST_FREE);
        end else if (init_we) begin
            slot[init_idx] <= init_ent;
        end else if (alloc_en) begin
            slot[rd_vpn] <= '{valid: 1'b1, ppn: next_free};
            next_free    <= next_free + PPN_W'(1);
        end
    end

endmodule

// File: rtl/xl_ctrl.sv
module xl_ctrl
    import xl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    output logic             ready,
    output logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_hit,
    input  logic [PPN_W-1:0] lk_ppn,
    output logic             touch_en,
    output logic             fill_en,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [PPN_W-1:0] fill_ppn,
    input  pte_t             pte,
    input  logic [PPN_W-1:0] alloc_ppn,
    output logic             alloc_en,
    output logic             resp_valid,
    output rcode_e           resp_code,
    output logic [PA_W-1:0]  resp_pa
);

    typedef enum logic {ST_IDLE, ST_WALK} state_e;

    state_e            state;
    logic [VPN_W-1:0]  w_vpn;
    logic [OFFS_W-1:0] w_off;
    logic              accept;

    assign ready    = (state == ST_IDLE);
    assign accept   = req_valid && ready;
    assign lk_vpn   = ready ? req_va[VA_W-1:OFFS_W] : w_vpn;
    assign touch_en = accept && lk_hit;
    assign fill_en  = (state == ST_WALK);
    assign fill_vpn = w_vpn;
    assign fill_ppn = pte.valid ? pte.ppn : alloc_ppn;
    assign alloc_en = fill_en && !pte.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            w_vpn      <= '0;
            w_off      <= '0;
            resp_valid <= 1'b0;
            resp_code  <= RC_HIT;
            resp_pa    <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (lk_hit) begin
                            resp_valid <= 1'b1;
                            resp_code  <= RC_HIT;
                            resp_pa    <= {lk_ppn, req_va[OFFS_W-1:0]};
                        end else begin
                            w_vpn <= req_va[VA_W-1:OFFS_W];
                            w_off <= req_va[OFFS_W-1:0];
                            state <= ST_WALK;
                        end
                    end
                end
                ST_WALK: begin
                    resp_valid <= 1'b1;
                    resp_code  <= pte.valid ? RC_TABLE : RC_FAULT;
                    resp_pa    <= {fill_ppn, w_off};
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vmem_xlate.sv
module vmem_xlate
    import xl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    output logic              ready,
    output logic              resp_valid,
    output logic [1:0]        resp_code,
    output logic [PA_W-1:0]   resp_pa,
    input  logic              init_tlb_we,
    input  logic [TIDX_W-1:0] init_tlb_idx,
    input  logic              init_tlb_valid,
    input  logic [VPN_W-1:0]  init_tlb_tag,
    input  logic [PPN_W-1:0]  init_tlb_ppn,
    input  logic [AGE_W-1:0]  init_tlb_age,
    input  logic              init_pt_we,
    input  logic [VPN_W-1:0]  init_pt_idx,
    input  logic              init_pt_valid,
    input  logic [PPN_W-1:0]  init_pt_ppn,
    input  logic [TIDX_W-1:0] peek_tlb_idx,
    output logic              peek_tlb_valid,
    output logic [VPN_W-1:0]  peek_tlb_tag,
    output logic [PPN_W-1:0]  peek_tlb_ppn,
    output logic [AGE_W-1:0]  peek_tlb_age,
    input  logic [VPN_W-1:0]  peek_pt_idx,
    output logic              peek_pt_valid,
    output logic [PPN_W-1:0]  peek_pt_ppn
);

    logic [VPN_W-1:0] lk_vpn;
    logic             lk_hit;
    logic [PPN_W-1:0] lk_ppn;
    logic             touch_en;
    logic             fill_en;
    logic [VPN_W-1:0] fill_vpn;
    logic [PPN_W-1:0] fill_ppn;
    logic             alloc_en;
    logic [PPN_W-1:0] alloc_ppn;
    pte_t             pte;
    rcode_e           code;
    tlbe_t            tlb_init_ent;
    tlbe_t            tlb_peek_ent;
    pte_t             pt_init_ent;
    pte_t             pt_peek_ent;

    assign tlb_init_ent = '{valid: init_tlb_valid, tag: init_tlb_tag,
                            ppn: init_tlb_ppn, age: init_tlb_age};
    assign pt_init_ent  = '{valid: init_pt_valid, ppn: init_pt_ppn};

    xl_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_va     (req_va),
        .ready      (ready),
        .lk_vpn     (lk_vpn),
        .lk_hit     (lk_hit),
        .lk_ppn     (lk_ppn),
        .touch_en   (touch_en),
        .fill_en    (fill_en),
        .fill_vpn   (fill_vpn),
        .fill_ppn   (fill_ppn),
        .pte        (pte),
        .alloc_ppn  (alloc_ppn),
        .alloc_en   (alloc_en),
        .resp_valid (resp_valid),
        .resp_code  (code),
        .resp_pa    (resp_pa)
    );

    xl_tlb u_tlb (
        .clk      (clk),
        .rst      (rst),
        .lk_vpn   (lk_vpn),
        .lk_hit   (lk_hit),
        .lk_ppn   (lk_ppn),
        .touch_en (touch_en),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_ppn (fill_ppn),
        .init_we  (init_tlb_we),
        .init_idx (init_tlb_idx),
        .init_ent (tlb_init_ent),
        .peek_idx (peek_tlb_idx),
        .peek_ent (tlb_peek_ent)
    );

    xl_ptab u_ptab (
        .clk       (clk),
        .rst       (rst),
        .rd_vpn    (fill_vpn),
        .rd_ent    (pte),
        .alloc_en  (alloc_en),
        .alloc_ppn (alloc_ppn),
        .init_we   (init_pt_we),
        .init_idx  (init_pt_idx),
        .init_ent  (pt_init_ent),
        .peek_idx  (peek_pt_idx),
        .peek_ent  (pt_peek_ent)
    );

    assign resp_code      = code;
    assign peek_tlb_valid = tlb_peek_ent.valid;
    assign peek_tlb_tag   = tlb_peek_ent.tag;
    assign peek_tlb_ppn   = tlb_peek_ent.ppn;
    assign peek_tlb_age   = tlb_peek_ent.age;
    assign peek_pt_valid  = pt_peek_ent.valid;
    assign peek_pt_ppn    = pt_peek_ent.ppn;

endmodule

// File: rtl/xl_checker.sv
module xl_checker
    import xl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             ready,
    input logic             resp_valid,
    input logic [1:0]       resp_code,
    input logic [PA_W-1:0]  resp_pa,
    input logic [PPN_W-1:0] alloc_ppn
);

    assert_code_legal_R2: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> resp_code != 2'b11);

    assert_hit_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_code == 2'b00) |-> $past(req_valid && ready));

    assert_walk_answers_R7: assert property (@(posedge clk) disable iff (rst)
        !ready |=> (resp_valid && resp_code != 2'b00 && ready));

    assert_miss_two_cycles_R3: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_code != 2'b00) |-> $past(!ready));

    assert_fault_ppn_R4: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_code == 2'b10) |->
            (resp_pa[PA_W-1:OFFS_W] == $past(alloc_ppn)));

    assert_alloc_step_R4: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_code == 2'b10) |->
            (alloc_ppn == $past(alloc_ppn) + PPN_W'(1)));

endmodule

bind vmem_xlate xl_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .ready      (ready),
    .resp_valid (resp_valid),
    .resp_code  (resp_code),
    .resp_pa    (resp_pa),
    .alloc_ppn  (alloc_ppn)
);

// File: tb/vmem_xlate_tb.sv
module vmem_xlate_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_va = '0;
    logic        ready;
    logic        resp_valid;
    logic [1:0]  resp_code;
    logic [16:0] resp_pa;
    logic        init_tlb_we = 1'b0;
    logic [1:0]  init_tlb_idx = '0;
    logic        init_tlb_valid = 1'b0;
    logic [3:0]  init_tlb_tag = '0;
    logic [4:0]  init_tlb_ppn = '0;
    logic [2:0]  init_tlb_age = '0;
    logic        init_pt_we = 1'b0;
    logic [3:0]  init_pt_idx = '0;
    logic        init_pt_valid = 1'b0;
    logic [4:0]  init_pt_ppn = '0;
    logic [1:0]  peek_tlb_idx = '0;
    logic        peek_tlb_valid;
    logic [3:0]  peek_tlb_tag;
    logic [4:0]  peek_tlb_ppn;
    logic [2:0]  peek_tlb_age;
    logic [3:0]  peek_pt_idx = '0;
    logic        peek_pt_valid;
    logic [4:0]  peek_pt_ppn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state
    int mt_v [4];
    int mt_tag [4];
    int mt_ppn [4];
    int mt_age [4];
    int mp_v [16];
    int mp_ppn [16];
    int m_free;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vmem_xlate u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_touch(input int idx);
        int pivot;
        pivot = mt_age[idx];
        for (int j = 0; j < 4; j++) begin
            if (j == idx) mt_age[j] = 4;
            else if (mt_age[j] > pivot) mt_age[j] = mt_age[j] - 1;
        end
    endtask

    task automatic tlb_load(input int idx, input int v, input int tag, input int ppn, input int age);
        @(negedge clk);
        init_tlb_we = 1'b1; init_tlb_idx = 2'(idx); init_tlb_valid = v[0];
        init_tlb_tag = 4'(tag); init_tlb_ppn = 5'(ppn); init_tlb_age = 3'(age);
        @(negedge clk);
        init_tlb_we = 1'b0;
        mt_v[idx] = v; mt_tag[idx] = tag; mt_ppn[idx] = ppn; mt_age[idx] = age;
    endtask

    task automatic pt_load(input int idx, input int v, input int ppn);
        @(negedge clk);
        init_pt_we = 1'b1; init_pt_idx = 4'(idx); init_pt_valid = v[0]; init_pt_ppn = 5'(ppn);
        @(negedge clk);
        init_pt_we = 1'b0;
        mp_v[idx] = v; mp_ppn[idx] = ppn;
    endtask

    task automatic check_state(input string tag);
        for (int i = 0; i < 4; i++) begin
            peek_tlb_idx = 2'(i);
            #1;
            chk(peek_tlb_valid == mt_v[i][0], {tag, " R6 tlb valid"}, int'(peek_tlb_valid), mt_v[i]);
            if (mt_v[i] != 0) begin
                chk(int'(peek_tlb_tag) == mt_tag[i], {tag, " R6 tlb tag"}, int'(peek_tlb_tag), mt_tag[i]);
                chk(int'(peek_tlb_ppn) == mt_ppn[i], {tag, " R6 tlb ppn"}, int'(peek_tlb_ppn), mt_ppn[i]);
            end
            chk(int'(peek_tlb_age) == mt_age[i], {tag, " R5 tlb age"}, int'(peek_tlb_age), mt_age[i]);
        end
        for (int i = 0; i < 16; i++) begin
            peek_pt_idx = 4'(i);
            #1;
            chk(peek_pt_valid == mp_v[i][0], {tag, " R4 pt valid"}, int'(peek_pt_valid), mp_v[i]);
            if (mp_v[i] != 0)
                chk(int'(peek_pt_ppn) == mp_ppn[i], {tag, " R4 pt ppn"}, int'(peek_pt_ppn), mp_ppn[i]);
        end
    endtask

    // One translation; returns the observed code. poke holds the request during the walk.
    task automatic lookup(input logic [15:0] va, input bit poke, output int got_code);
        int vpn, hi, ecode, eppn, lat, vic, best;
        vpn = int'(va[15:12]);
        hi = -1;
        for (int i = 0; i < 4; i++)
            if (mt_v[i] != 0 && mt_tag[i] == vpn) hi = i;
        if (hi >= 0) begin
            ecode = 0; eppn = mt_ppn[hi];
            model_touch(hi);
        end else begin
            if (mp_v[vpn] != 0) begin
                ecode = 1; eppn = mp_ppn[vpn];
            end else begin
                ecode = 2; eppn = m_free;
                mp_v[vpn] = 1; mp_ppn[vpn] = m_free; m_free++;
            end
            vic = -1;
            for (int i = 0; i < 4; i++)
                if (vic < 0 && mt_v[i] == 0) vic = i;
            if (vic < 0) begin
                best = 99;
                for (int i = 0; i < 4; i++)
                    if (mt_age[i] < best) begin best = mt_age[i]; vic = i; end
            end
            model_touch(vic);
            mt_v[vic] = 1; mt_tag[vic] = vpn; mt_ppn[vic] = eppn;
        end

        @(negedge clk);
        req_valid = 1'b1; req_va = va;
        @(posedge clk); #1;
        lat = 1;
        if (!resp_valid) begin
            chk(ready == 1'b0, "R7 ready low in walk", int'(ready), 0);
            if (poke) req_va = va ^ 16'h5000;
            else req_valid = 1'b0;
            @(posedge clk); #1;
            lat = 2;
        end
        req_valid = 1'b0;
        got_code = int'(resp_code);
        chk(resp_valid == 1'b1, "R2 response present", int'(resp_valid), 1);
        chk(got_code == ecode, "R3 R4 result code", got_code, ecode);
        chk(lat == (ecode == 0 ? 1 : 2), "R2 R3 latency", lat, ecode == 0 ? 1 : 2);
        chk(int'(resp_pa[16:12]) == eppn, "R1 physical page", int'(resp_pa[16:12]), eppn);
        chk(resp_pa[11:0] == va[11:0], "R1 offset passthrough", int'(resp_pa[11:0]), int'(va[11:0]));
        if (poke) begin
            @(posedge clk); #1;
            chk(resp_valid == 1'b0, "R7 busy request ignored", int'(resp_valid), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c;
        int exp_codes [7];
        logic [15:0] stream [7];
        stream = '{16'h0FFF, 16'h7A28, 16'h3DAD, 16'h3A98, 16'h1C19, 16'h1000, 16'h22D0};
        exp_codes = '{1, 0, 0, 0, 2, 0, 2};

        for (int i = 0; i < 4; i++) begin
            mt_v[i] = 0; mt_tag[i] = 0; mt_ppn[i] = 0; mt_age[i] = i + 1;
        end
        for (int i = 0; i < 16; i++) begin mp_v[i] = 0; mp_ppn[i] = 0; end
        m_free = 13;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(ready == 1'b1, "R8 ready after reset", int'(ready), 1);
        chk(resp_valid == 1'b0, "R8 no response after reset", int'(resp_valid), 0);
        check_state("R8 reset");

        // R9: preload buffer and table
        tlb_load(0, 1, 11, 12, 2);
        tlb_load(1, 1, 7, 4, 3);
        tlb_load(2, 1, 3, 6, 4);
        tlb_load(3, 0, 4, 9, 1);
        pt_load(0, 1, 5);  pt_load(3, 1, 6);  pt_load(4, 1, 9);
        pt_load(5, 1, 11); pt_load(7, 1, 4);  pt_load(10, 1, 3);
        pt_load(11, 1, 12);
        check_state("R9 preload");

        // Worked stream: model and fixed expectations must agree
        for (int i = 0; i < 7; i++) begin
            lookup(stream[i], 1'b0, c);
            chk(c == exp_codes[i], "R6 stream code", c, exp_codes[i]);
        end
        check_state("R6 after stream");

        // Sweep every page, ascending then descending, some with busy pokes
        for (int v = 0; v < 16; v++) begin
            lookup(16'((v << 12) | (v * 16'h0111)), v[0], c);
        end
        check_state("R5 sweep up");
        for (int v = 15; v >= 0; v--) begin
            lookup(16'((v << 12) | 16'hABC), 1'b1, c);
            lookup(16'((v << 12) | 16'h123), 1'b0, c);
        end
        check_state("R4 sweep down");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule